// File: doc/BRIEF.md
# Banked Host Register Window with Packet-Buffer Pointer Port

This block is the host-facing register front end of a network controller. The host sees a 16-byte window. Two offsets are the same in every bank; the meaning of the rest depends on a two-bit bank number. The window holds the transmit control, receive control, configuration, control, general-purpose and early-receive words. It also holds a 16-bit pointer and a four-byte data port that read and write one byte of packet-buffer RAM per access.

The pointer chooses a page and a byte offset inside it. The page is either the head of the receive queue or the host's current packet number; both arrive as inputs from the allocator. In auto-increment mode each data-port byte advances the offset and leaves the flag bits alone. Otherwise the low address bits of the access are added to the offset. The host issues byte, 16-bit or 32-bit accesses. Each is carried out as a run of byte steps, one per clock, and a single response closes it.

Top module: `nic_reg_window`

## Requirements
- R1: Offset 14 reads the bank number in bits 1:0 (upper bits 0) in every bank, and a write there stores bits 1:0 of the byte. Offset 15 reads 0x33 in every bank and ignores writes.
- R2: After reset the bank is 0, configuration is 0xA0B1, control is 0x1210, early-receive is 0x1F, and transmit control, receive control, general-purpose and pointer are 0.
- R3: In bank 2, offsets 8 to 11 are the data port. Pointer bit 15 set selects the `rx_head_page` page and clear selects `pkt_num`. Pointer bits 10:0 give the byte offset.
- R4: With pointer bit 14 set, a data-port byte uses offset bits 10:0 as they stand, then increments bits 10:0 modulo 2048 with bits 15:11 unchanged.
- R5: With pointer bit 14 clear, the RAM offset is bits 10:0 plus address bits 1:0, modulo 2048, and the pointer does not change.
- R6: In bank 2, offsets 6 and 7 are the pointer low and high bytes. A read of offset 7 returns the high byte ANDed with 0xF7.
- R7: Writing bank 0 offset 5 (receive control high byte) with bit 7 set returns every register of R2 to its reset value and raises `soft_rst` for one cycle.
- R8: A write to bank 1 offset 12 (control low byte) stores the byte with bits 1:0 forced to 0. A write to bank 3 offset 12 keeps only bits 4:0.
- R9: Bank 0 offset 8 reads the page count (PAGES). Bank 3 offset 10 reads revision 0x91.
- R10: A 16-bit access is two byte steps, at the address and the address plus 1 (low byte first). A 32-bit access is four steps in ascending order, using `req_wdata`/`rsp_rdata` byte k for step k. A 32-bit write at offset 12 performs only the steps at 14 and 15, with data bytes 2 and 3. Addresses wrap modulo 16.
- R11: Offsets that are not listed read 0 and ignore writes. Register map: bank 0: 0/1 transmit control, 4/5 receive control. Bank 1: 0/1 configuration, 10/11 general-purpose, 12/13 control. Bank 3: 12 early-receive.
- R12: An access is accepted when `req_valid` is high and `req_ready` is high. Its steps run on the following cycles. `rsp_valid` pulses for one cycle after the last step. `rsp_rdata` holds the read bytes, and holds 0 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half, 2 or 3 word |
| req_addr | input | 4 | Window offset |
| req_wdata | input | 32 | Write data, byte k for step k |
| req_ready | output | 1 | Ready to accept an access |
| rsp_valid | output | 1 | Access complete, one-cycle pulse |
| rsp_rdata | output | 32 | Read result |
| ram_en | output | 1 | Packet-buffer access this cycle |
| ram_we | output | 1 | Packet-buffer write this cycle |
| ram_page | output | PAGE_W | Page selected by the pointer |
| ram_offset | output | 11 | Byte offset inside the page |
| ram_wdata | output | 8 | Byte to write |
| ram_rdata | input | 8 | Byte read, combinational from address |
| rx_head_page | input | PAGE_W | Head page of the receive queue |
| pkt_num | input | PAGE_W | Host packet number |
| soft_rst | output | 1 | One-cycle pulse on software reset |
| tx_ctrl | output | 16 | Transmit control word |
| rx_ctrl | output | 16 | Receive control word |
| cfg_word | output | 16 | Configuration word |
| ctl_word | output | 16 | Control word |
| gp_word | output | 16 | General-purpose word |
| erx_level | output | 5 | Early-receive threshold |

## Verification
A data-port byte and the pointer update it causes land on the same clock edge. The RAM address must use the offset from before the increment, while the pointer advances for the next step. Wide data-port accesses in auto-increment mode start next to the 2047 boundary so that steps within one access cross the wrap. Both the bench RAM contents and the pointer read back afterwards are compared with a reference model. A random mix of wide accesses over all banks, including pointer writes followed by data bytes in the same 32-bit access, is also compared access by access with that model.

// File: rtl/nic_reg_window.sv
module nic_reg_window #(
  parameter int PAGES = 4,
  parameter int PAGE_BYTES = 2048,
  parameter logic [7:0] REVISION = 8'h91,
  localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int OFS_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [3:0]        req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [PAGE_W-1:0] ram_page,
  output logic [OFS_W-1:0]  ram_offset,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  input  logic [PAGE_W-1:0] rx_head_page,
  input  logic [PAGE_W-1:0] pkt_num,
  output logic              soft_rst,
  output logic [15:0]       tx_ctrl,
  output logic [15:0]       rx_ctrl,
  output logic [15:0]       cfg_word,
  output logic [15:0]       ctl_word,
  output logic [15:0]       gp_word,
  output logic [4:0]        erx_level
);

  localparam logic [15:0] CFG_INIT = 16'hA0B1;
  localparam logic [15:0] CTL_INIT = 16'h1210;
  localparam logic [4:0]  ERX_INIT = 5'h1F;

  logic        busy, wr;
  logic [3:0]  cur_a;
  logic [1:0]  idx, last;
  logic [31:0] wdat, rd_acc;
  logic [1:0]  bank;
  logic [15:0] ptr;
  logic [7:0]  wb, rbyte;
  logic        is_data, soft_hit;

  assign req_ready  = !busy;
  assign rsp_rdata  = rd_acc;
  assign wb         = wdat[{idx, 3'b000} +: 8];
  assign is_data    = (bank == 2'd2) && (cur_a[3:2] == 2'b10);
  assign ram_en     = busy && is_data;
  assign ram_we     = ram_en && wr;
  assign ram_wdata  = wb;
  assign ram_page   = ptr[15] ? rx_head_page : pkt_num;
  assign ram_offset = ptr[14] ? ptr[OFS_W-1:0] : ptr[OFS_W-1:0] + OFS_W'(cur_a[1:0]);
  assign soft_hit   = busy && wr && (bank == 2'd0) && (cur_a == 4'd5) && wb[7];

  always_comb begin
    rbyte = 8'h00;
    if (cur_a == 4'd14) rbyte = {6'b0, bank};
    else if (cur_a == 4'd15) rbyte = 8'h33;
    else begin
      case (bank)
        2'd0: case (cur_a)
          4'd0: rbyte = tx_ctrl[7:0];
          4'd1: rbyte = tx_ctrl[15:8];
          4'd4: rbyte = rx_ctrl[7:0];
          4'd5: rbyte = rx_ctrl[15:8];
          4'd8: rbyte = 8'(PAGES);
          default: rbyte = 8'h00;
        endcase
        2'd1: case (cur_a)
          4'd0:  rbyte = cfg_word[7:0];
          4'd1:  rbyte = cfg_word[15:8];
          4'd10: rbyte = gp_word[7:0];
          4'd11: rbyte = gp_word[15:8];
          4'd12: rbyte = ctl_word[7:0];
          4'd13: rbyte = ctl_word[15:8];
          default: rbyte = 8'h00;
        endcase
        2'd2: begin
          if (cur_a == 4'd6) rbyte = ptr[7:0];
          else if (cur_a == 4'd7) rbyte = ptr[15:8] & 8'hF7;
          else if (is_data) rbyte = ram_rdata;
        end
        default: begin
          if (cur_a == 4'd10) rbyte = REVISION;
          else if (cur_a == 4'd12) rbyte = {3'b0, erx_level};
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; wr <= 1'b0; cur_a <= '0; idx <= '0; last <= '0;
      wdat <= '0; rd_acc <= '0; rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (!busy && req_valid) begin
        busy   <= 1'b1;
        wr     <= req_write;
        wdat   <= req_wdata;
        rd_acc <= '0;
        if (req_write && req_size[1] && req_addr == 4'hC) begin
          cur_a <= 4'hE; idx <= 2'd2; last <= 2'd3;
        end else begin
          cur_a <= req_addr; idx <= 2'd0;
          last  <= req_size[1] ? 2'd3 : {1'b0, req_size[0]};
        end
      end else if (busy) begin
        if (!wr) rd_acc[{idx, 3'b000} +: 8] <= rbyte;
        if (idx == last) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
        end else begin
          idx   <= idx + 2'd1;
          cur_a <= cur_a + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= '0; tx_ctrl <= '0; rx_ctrl <= '0; cfg_word <= CFG_INIT;
      ctl_word <= CTL_INIT; gp_word <= '0; ptr <= '0; erx_level <= ERX_INIT;
      soft_rst <= 1'b0;
    end else if (soft_hit) begin
      bank <= '0; tx_ctrl <= '0; rx_ctrl <= '0; cfg_word <= CFG_INIT;
      ctl_word <= CTL_INIT; gp_word <= '0; ptr <= '0; erx_level <= ERX_INIT;
      soft_rst <= 1'b1;
    end else begin
      soft_rst <= 1'b0;
      if (ram_en && ptr[14]) ptr[OFS_W-1:0] <= ptr[OFS_W-1:0] + 1'b1;
      if (busy && wr) begin
        if (cur_a == 4'd14) bank <= wb[1:0];
        else if (cur_a != 4'd15) begin
          case (bank)
            2'd0: case (cur_a)
              4'd0: tx_ctrl[7:0]  <= wb;
              4'd1: tx_ctrl[15:8] <= wb;
              4'd4: rx_ctrl[7:0]  <= wb;
              4'd5: rx_ctrl[15:8] <= wb;
              default: ;
            endcase
            2'd1: case (cur_a)
              4'd0:  cfg_word[7:0]  <= wb;
              4'd1:  cfg_word[15:8] <= wb;
              4'd10: gp_word[7:0]   <= wb;
              4'd11: gp_word[15:8]  <= wb;
              4'd12: ctl_word[7:0]  <= {wb[7:2], 2'b00};
              4'd13: ctl_word[15:8] <= wb;
              default: ;
            endcase
            2'd2: begin
              if (cur_a == 4'd6) ptr[7:0] <= wb;
              else if (cur_a == 4'd7) ptr[15:8] <= wb;
            end
            default: if (cur_a == 4'd12) erx_level <= wb[4:0];
          endcase
        end
      end
    end
  end

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ptr[14]) |=> (ptr == {$past(ptr[15:11]), $past(ptr[10:0]) + 11'd1}));

  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ptr[14]) |=> $stable(ptr));

  p_soft_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (cfg_word == CFG_INIT && ctl_word == CTL_INIT && ptr == 16'h0 && bank == 2'd0 && rx_ctrl == 16'h0));

  p_ctl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_word[1:0] == 2'b00);

  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!busy && !$past(rsp_valid)));

  p_ram_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> !req_ready);

endmodule

// File: tb/sim_nic_reg_window.sv
module sim_nic_reg_window;
  localparam int PAGES = 4;
  localparam int PW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = '0;
  logic [3:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, ram_en, ram_we, soft_rst;
  logic [31:0] rsp_rdata;
  logic [PW-1:0] ram_page, rx_head_page = '0, pkt_num = '0;
  logic [10:0] ram_offset;
  logic [7:0] ram_wdata, ram_rdata;
  logic [15:0] tx_ctrl, rx_ctrl, cfg_word, ctl_word, gp_word;
  logic [4:0] erx_level;

  always #4 clk = ~clk;

  nic_reg_window #(.PAGES(PAGES)) u0 (.*);

  logic [7:0] mem [PAGES][2048];
  logic [7:0] ref_mem [PAGES][2048];
  assign ram_rdata = mem[ram_page][ram_offset];
  always @(posedge clk) if (ram_we) mem[ram_page][ram_offset] <= ram_wdata;

  int n_chk = 0, n_fail = 0, soft_cnt = 0, last_lat = 0;
  always @(posedge clk) if (soft_rst) soft_cnt++;

  logic [1:0] m_bank;
  logic [15:0] m_tcr, m_rcr, m_cfg, m_ctl, m_gpr, m_ptr;
  logic [4:0] m_erx;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_bank = 0; m_tcr = 0; m_rcr = 0; m_cfg = 16'hA0B1; m_ctl = 16'h1210;
    m_gpr = 0; m_ptr = 0; m_erx = 5'h1F;
  endtask

  task automatic m_byte(input bit w, input logic [3:0] a, input logic [7:0] d, output logic [7:0] r);
    logic [10:0] off;
    r = 8'h00;
    if (a == 14) begin r = {6'b0, m_bank}; if (w) m_bank = d[1:0]; end
    else if (a == 15) r = 8'h33;
    else case (m_bank)
      0: case (a)
        0: begin r = m_tcr[7:0];  if (w) m_tcr[7:0] = d; end
        1: begin r = m_tcr[15:8]; if (w) m_tcr[15:8] = d; end
        4: begin r = m_rcr[7:0];  if (w) m_rcr[7:0] = d; end
        5: begin r = m_rcr[15:8]; if (w) begin if (d[7]) m_reset(); else m_rcr[15:8] = d; end end
        8: r = 8'(PAGES);
        default: ;
      endcase
      1: case (a)
        0:  begin r = m_cfg[7:0];  if (w) m_cfg[7:0] = d; end
        1:  begin r = m_cfg[15:8]; if (w) m_cfg[15:8] = d; end
        10: begin r = m_gpr[7:0];  if (w) m_gpr[7:0] = d; end
        11: begin r = m_gpr[15:8]; if (w) m_gpr[15:8] = d; end
        12: begin r = m_ctl[7:0];  if (w) m_ctl[7:0] = d & 8'hFC; end
        13: begin r = m_ctl[15:8]; if (w) m_ctl[15:8] = d; end
        default: ;
      endcase
      2: begin
        if (a == 6) begin r = m_ptr[7:0]; if (w) m_ptr[7:0] = d; end
        else if (a == 7) begin r = m_ptr[15:8] & 8'hF7; if (w) m_ptr[15:8] = d; end
        else if (a >= 8 && a <= 11) begin
          off = m_ptr[14] ? m_ptr[10:0] : m_ptr[10:0] + 11'(a[1:0]);
          if (w) ref_mem[m_ptr[15] ? rx_head_page : pkt_num][off] = d;
          else r = ref_mem[m_ptr[15] ? rx_head_page : pkt_num][off];
          if (m_ptr[14]) m_ptr[10:0] = m_ptr[10:0] + 11'd1;
        end
      end
      default: begin
        if (a == 10) r = 8'h91;
        else if (a == 12) begin r = {3'b0, m_erx}; if (w) m_erx = d[4:0]; end
      end
    endcase
  endtask

  task automatic xact(input string tag, input bit w, input logic [1:0] sz, input logic [3:0] a,
                      input logic [31:0] d, output logic [31:0] got);
    logic [31:0] exp;
    logic [7:0] rb;
    int first, n;
    exp = 0;
    if (w && sz[1] && a == 4'hC) begin first = 2; n = 4; end
    else begin first = 0; n = sz[1] ? 4 : (sz[0] ? 2 : 1); end
    for (int k = first; k < n; k++) begin
      m_byte(w, 4'(a + (k - first) + (first == 2 ? 2 : 0)), d[8*k +: 8], rb);
      if (!w) exp[8*k +: 8] = rb;
    end
    @(negedge clk);
    req_valid = 1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    last_lat = 1;
    while (!rsp_valid) begin @(negedge clk); last_lat++; end
    got = rsp_rdata;
    check({tag, " R10 model"}, got, exp);
  endtask

  task automatic wr(input logic [1:0] sz, input logic [3:0] a, input logic [31:0] d);
    logic [31:0] g;
    xact("wr", 1'b1, sz, a, d, g);
  endtask

  task automatic rd(input string tag, input logic [1:0] sz, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] g;
    xact(tag, 1'b0, sz, a, 0, g);
    check(tag, g, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    finish_run();
  end

  initial begin
    int s0;
    logic [31:0] g;
    for (int p = 0; p < PAGES; p++)
      for (int o = 0; o < 2048; o++) begin mem[p][o] = 0; ref_mem[p][o] = 0; end
    m_reset();
    s0 = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R2 cfg", {16'h0, cfg_word}, 32'hA0B1);
    check("R2 ctl", {16'h0, ctl_word}, 32'h1210);
    check("R2 erx", {27'h0, erx_level}, 32'h1F);
    check("R2 ctrl words", {tx_ctrl, rx_ctrl}, 32'h0);
    check("R12 ready", {31'h0, req_ready}, 32'h1);
    rd("R2 bank0 tcr/rcr", 2'd2, 4'd0, 32'h0000_0000);
    wr(2'd0, 4'd14, 32'h1);
    rd("R2 bank1 ctl/bank", 2'd2, 4'd12, 32'h3301_1210);
    check("R12 word latency", last_lat, 5);
    rd("R2 bank1 cfg", 2'd2, 4'd0, 32'h0000_A0B1);
    wr(2'd0, 4'd15, 32'hFF);
    rd("R1 bank/const", 2'd1, 4'd14, 32'h0000_3301);
    check("R12 half latency", last_lat, 3);
    wr(2'd0, 4'd12, 32'hFF);
    rd("R8 ctl low", 2'd0, 4'd12, 32'h0000_00FC);
    check("R12 byte latency", last_lat, 2);
    wr(2'd2, 4'd12, 32'h0002_5555);
    rd("R10 wide write at 12 sets bank", 2'd0, 4'd14, 32'h2);
    wr(2'd0, 4'd14, 32'h1);
    rd("R10 wide write at 12 spares ctl", 2'd1, 4'd12, 32'h0000_12FC);
    wr(2'd0, 4'd14, 32'h3);
    rd("R9 revision", 2'd0, 4'd10, 32'h91);
    wr(2'd0, 4'd12, 32'hFF);
    rd("R8 erx mask", 2'd0, 4'd12, 32'h1F);
    wr(2'd0, 4'd0, 32'hFF);
    rd("R11 unimplemented", 2'd0, 4'd0, 32'h0);
    wr(2'd0, 4'd14, 32'h0);
    rd("R9 page count", 2'd1, 4'd8, 32'h0004);
    wr(2'd0, 4'd14, 32'h2);
    pkt_num = 1; rx_head_page = 2;
    wr(2'd1, 4'd6, 32'hFFFF);
    rd("R6 ptr high mask", 2'd0, 4'd7, 32'hF7);
    wr(2'd1, 4'd6, 32'h47FF);
    wr(2'd0, 4'd8, 32'h5A);
    check("R4 byte at 2047", {24'h0, mem[1][2047]}, 32'h5A);
    rd("R4 wrap keeps flags", 2'd1, 4'd6, 32'h4000);
    wr(2'd1, 4'd6, 32'h47FE);
    wr(2'd2, 4'd8, 32'h4433_2211);
    check("R4 wide across wrap", {mem[1][1], mem[1][0], mem[1][2047], mem[1][2046]}, 32'h4433_2211);
    rd("R4 ptr after wide", 2'd1, 4'd6, 32'h4002);
    wr(2'd1, 4'd6, 32'h0010);
    wr(2'd2, 4'd8, 32'hDDCC_BBAA);
    check("R5 offset plus addr", {mem[1][19], mem[1][18], mem[1][17], mem[1][16]}, 32'hDDCC_BBAA);
    rd("R5 ptr unchanged", 2'd1, 4'd6, 32'h0010);
    rd("R5 read back", 2'd2, 4'd8, 32'hDDCC_BBAA);
    wr(2'd1, 4'd6, 32'h8020);
    wr(2'd0, 4'd9, 32'h77);
    check("R3 rx head page", {24'h0, mem[2][33]}, 32'h77);
    check("R3 pkt page untouched", {24'h0, mem[1][33]}, 32'h0);
    wr(2'd0, 4'd14, 32'h1);
    wr(2'd1, 4'd10, 32'h1234);
    wr(2'd0, 4'd14, 32'h0);
    wr(2'd0, 4'd0, 32'h01);
    wr(2'd1, 4'd4, 32'h8000);
    @(negedge clk);
    check("R7 soft pulse count", soft_cnt, 1);
    check("R7 gp cleared", {16'h0, gp_word}, 32'h0);
    check("R7 tx cleared", {16'h0, tx_ctrl}, 32'h0);
    rd("R7 bank cleared", 2'd0, 4'd14, 32'h0);
    for (int i = 0; i < 900; i++) begin
      logic [1:0] sz;
      pkt_num = PW'($urandom % PAGES);
      rx_head_page = PW'($urandom % PAGES);
      sz = 2'($urandom % 3);
      xact("R10 random", 1'($urandom % 2), sz, 4'($urandom % 16), $urandom, g);
    end
    finish_run();
  end
endmodule